// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Checker

This block sits in the decode stage of an in-order pipeline that feeds one integer path and three floating-point units with different latencies. Each cycle it sees at most one decoded instruction: an operation class, a destination register with a write flag, and two source registers with use flags. It decides whether the instruction may leave decode now or must hold. The block combines four checks. The first is a read-after-write check against per-register countdowns. The second is a write-after-write ordering check. The third is a look-ahead reservation ring for the single MEM/write-back slot. The fourth is a busy countdown for the divider, which cannot take a new operation every cycle. The arithmetic, the forwarding muxes and the register file are not part of this block.

When an instruction issues, the block reports how many cycles later it will occupy the MEM/write-back slot. In the same cycle it books that slot and starts the countdown for its destination. Results from different units can therefore complete out of program order without two of them ever needing the write port in the same cycle.

Top module: `issue_hazard_unit`

## Requirements
- R1: `op_i` encodes 0 = integer/load/store, 1 = FP add, 2 = FP multiply, 3 = FP divide. `wb_dist_o` equals the unit latency plus one: 2, 4, 7 and 25 cycles with the default latencies 1, 3, 6 and 24.
- R2: A valid instruction with an enabled source register stalls while that register's pending result is more than `FWD_DIST` (default 0) cycles from its write-back. It issues in the cycle the distance reaches `FWD_DIST`.
- R3: A valid instruction stalls when its write-back cycle is already booked by an earlier issued instruction.
- R4: A valid instruction that writes a register stalls while an earlier write to the same register is at least as many cycles away as its own write-back distance.
- R5: After a divide issues in cycle t, no other divide issues before cycle t+25. A divide that is otherwise free issues in cycle t+25.
- R6: Add and multiply accept independent instructions in consecutive cycles. An independent short instruction may issue after a long one and complete before it.
- R7: An instruction with `valid_i` low raises neither `issue_o` nor `stall_o`. It books no write-back slot, no register countdown and no divider time.
- R8: A source whose use flag is low is ignored by the read-after-write check.
- R9: Reset clears all slot bookings, register countdowns and the divider countdown.
- R10: `issue_o` and `stall_o` are never both high, and one of them is high whenever `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decode slot holds an instruction |
| op_i | input | 2 | Operation class (see R1) |
| rd_i | input | 5 | Destination register |
| rd_we_i | input | 1 | Instruction writes `rd_i` |
| rs1_i | input | 5 | First source register |
| rs1_en_i | input | 1 | First source is read |
| rs2_i | input | 5 | Second source register |
| rs2_en_i | input | 1 | Second source is read |
| issue_o | output | 1 | Instruction leaves decode this cycle |
| stall_o | output | 1 | Instruction holds in decode |
| wb_dist_o | output | 5 | Cycles from issue to the instruction's MEM/write-back slot |

## Verification
A write-back slot clash and a register-ordering hazard can fall in the same cycle. This happens when a short instruction targets a register whose long-latency write is still pending, and the two writes would also meet in the same write-back cycle. The stimulus table keeps these cases apart on purpose. One row provokes only the write-after-write stall, with a free slot. Another provokes only the slot clash, with an unrelated destination. A following row then shows that each stall releases in exactly the cycle the requirements predict. The same approach separates the divider countdown from the slot booking of the waiting divide.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_ADD = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } op_cls_e;
endpackage

// File: rtl/wb_slot_ring.sv
// Look-ahead booking of the single MEM/write-back slot; bit k = k cycles from now.
module wb_slot_ring #(
  parameter int DEPTH = 26,
  parameter int OFS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             book_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic             busy_o
);
  logic [DEPTH-1:0] res_q, res_d;

  always_comb begin
    res_d = res_q >> 1;
    if (book_i) res_d[ofs_i - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign busy_o = res_q[ofs_i];

  a_r3_no_double_book: assert property (@(posedge clk_i) disable iff (!rst_ni)
    book_i |-> !res_q[ofs_i]);
  a_r3_booking_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (book_i && ofs_i > 1) |=> res_q[$past(ofs_i) - 1'b1]);
endmodule

// File: rtl/div_busy_ctr.sv
module div_busy_ctr #(
  parameter int DIV_II = 25,
  localparam int CW    = $clog2(DIV_II + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(DIV_II - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r5_div_idle_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> cnt_q == '0);
  a_r5_div_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !start_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/reg_pend_table.sv
// Per-register countdown: cycles until the pending result reaches write-back.
module reg_pend_table #(
  parameter int NREG = 32,
  parameter int CW   = 5,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [AW-1:0] set_reg_i,
  input  logic [CW-1:0] set_val_i,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  output logic [CW-1:0] rs1_dist_o,
  output logic [CW-1:0] rs2_dist_o,
  output logic [CW-1:0] rd_dist_o
);
  logic [CW-1:0] pend_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) pend_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (set_i && set_reg_i == AW'(i)) pend_q[i] <= set_val_i;
        else if (pend_q[i] != '0)          pend_q[i] <= pend_q[i] - 1'b1;
      end
    end
  end

  assign rs1_dist_o = pend_q[rs1_i];
  assign rs2_dist_o = pend_q[rs2_i];
  assign rd_dist_o  = pend_q[set_reg_i];

  a_r4_write_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> rd_dist_o <= set_val_i);
  a_r9_set_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q[$past(set_reg_i)] == $past(set_val_i));
endmodule

// File: rtl/issue_hazard_unit.sv
module issue_hazard_unit
  import hzd_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 3,
  parameter int MUL_LAT  = 6,
  parameter int DIV_LAT  = 24,
  parameter int DIV_II   = 25,
  parameter int FWD_DIST = 0,
  localparam int AW      = $clog2(NREG),
  localparam int DEPTH   = DIV_LAT + 2,
  localparam int OFS_W   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [AW-1:0]    rd_i,
  input  logic             rd_we_i,
  input  logic [AW-1:0]    rs1_i,
  input  logic             rs1_en_i,
  input  logic [AW-1:0]    rs2_i,
  input  logic             rs2_en_i,
  output logic             issue_o,
  output logic             stall_o,
  output logic [OFS_W-1:0] wb_dist_o
);
  op_cls_e          op;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] rs1_dist, rs2_dist, rd_dist;
  logic             slot_busy, div_busy;
  logic             raw_hz, waw_hz, div_hz, any_hz;
  logic             is_div;

  assign op = op_cls_e'(op_i);

  always_comb begin
    unique case (op)
      OP_INT:  ofs = OFS_W'(INT_LAT + 1);
      OP_ADD:  ofs = OFS_W'(ADD_LAT + 1);
      OP_MUL:  ofs = OFS_W'(MUL_LAT + 1);
      default: ofs = OFS_W'(DIV_LAT + 1);
    endcase
  end

  assign is_div = (op == OP_DIV);

  reg_pend_table #(.NREG(NREG), .CW(OFS_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (issue_o && rd_we_i),
    .set_reg_i  (rd_i),
    .set_val_i  (ofs - 1'b1),
    .rs1_i      (rs1_i),
    .rs2_i      (rs2_i),
    .rs1_dist_o (rs1_dist),
    .rs2_dist_o (rs2_dist),
    .rd_dist_o  (rd_dist)
  );

  wb_slot_ring #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .book_i (issue_o),
    .ofs_i  (ofs),
    .busy_o (slot_busy)
  );

  div_busy_ctr #(.DIV_II(DIV_II)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue_o && is_div),
    .busy_o  (div_busy)
  );

  assign raw_hz = (rs1_en_i && rs1_dist > OFS_W'(FWD_DIST))
               || (rs2_en_i && rs2_dist > OFS_W'(FWD_DIST));
  assign waw_hz = rd_we_i && (rd_dist >= ofs);
  assign div_hz = is_div && div_busy;
  assign any_hz = raw_hz || waw_hz || slot_busy || div_hz;

  assign issue_o   = valid_i && !any_hz;
  assign stall_o   = valid_i && any_hz;
  assign wb_dist_o = ofs;

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && stall_o));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!issue_o && !stall_o));
  a_r2_src1_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && rs1_en_i) |-> rs1_dist <= OFS_W'(FWD_DIST));
  a_r2_src2_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && rs2_en_i) |-> rs2_dist <= OFS_W'(FWD_DIST));
  a_r5_div_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && is_div) |=> !(issue_o && is_div));
endmodule

// File: tb/tb_issue_hazard_unit.sv
module tb_issue_hazard_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [4:0] rd_i = '0, rs1_i = '0, rs2_i = '0;
  logic       rd_we_i = 1'b0, rs1_en_i = 1'b0, rs2_en_i = 1'b0;
  logic       issue_o, stall_o;
  logic [4:0] wb_dist_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  issue_hazard_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .rd_i(rd_i), .rd_we_i(rd_we_i), .rs1_i(rs1_i), .rs1_en_i(rs1_en_i),
    .rs2_i(rs2_i), .rs2_en_i(rs2_en_i), .issue_o(issue_o), .stall_o(stall_o),
    .wb_dist_o(wb_dist_o)
  );

  typedef struct packed {
    logic       v;
    logic [1:0] op;
    logic [4:0] rd;
    logic       we;
    logic [4:0] rs1;
    logic       e1;
    logic [4:0] rs2;
    logic       e2;
    logic       xi;
    logic [4:0] xw;
    logic [3:0] req;
  } row_t;

  localparam int NROW = 21;
  // one row per cycle, cycle index = row index
  localparam row_t TBL [NROW] = '{
    '{1'b1, 2'd0, 5'd1,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd1},  // c0 load, R1
    '{1'b1, 2'd1, 5'd2,  1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd4,  4'd2},  // c1 R2 wait on load
    '{1'b1, 2'd1, 5'd2,  1'b1, 5'd1, 1'b1, 5'd0, 1'b0, 1'b1, 5'd4,  4'd2},  // c2 R2 release
    '{1'b1, 2'd2, 5'd3,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd7,  4'd1},  // c3 mul, R1
    '{1'b1, 2'd0, 5'd4,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd2,  4'd3},  // c4 R3 slot c6 taken
    '{1'b1, 2'd0, 5'd4,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd3},  // c5 R3 slot c7 free
    '{1'b1, 2'd0, 5'd3,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd2,  4'd4},  // c6 R4 mul rd3 4 away
    '{1'b1, 2'd1, 5'd3,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd4,  4'd4},  // c7 R4 3 < 4
    '{1'b1, 2'd3, 5'd5,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd25, 4'd1},  // c8 div, R1
    '{1'b1, 2'd3, 5'd6,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd25, 4'd5},  // c9 R5 busy
    '{1'b0, 2'd1, 5'd7,  1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 5'd4,  4'd7},  // c10 R7 invalid
    '{1'b1, 2'd0, 5'd9,  1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd7},  // c11
    '{1'b1, 2'd0, 5'd10, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd7},  // c12 R7 slot c14 free
    '{1'b1, 2'd0, 5'd13, 1'b1, 5'd0, 1'b0, 5'd7, 1'b1, 1'b1, 5'd2,  4'd7},  // c13 R7 rd7 not pending
    '{1'b1, 2'd0, 5'd14, 1'b1, 5'd5, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd8},  // c14 R8 unused src
    '{1'b1, 2'd0, 5'd14, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 1'b0, 5'd2,  4'd2},  // c15 R2 div result
    '{1'b1, 2'd1, 5'd11, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd4,  4'd6},  // c16 R6 add
    '{1'b1, 2'd1, 5'd12, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd4,  4'd6},  // c17 R6 add II 1
    '{1'b1, 2'd2, 5'd15, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd7,  4'd6},  // c18 R6 mul
    '{1'b1, 2'd2, 5'd16, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd7,  4'd6},  // c19 R6 mul II 1
    '{1'b1, 2'd0, 5'd17, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd2,  4'd6}   // c20 R6 overtakes
  };

  task automatic chk(input int req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    valid_i = r.v; op_i = r.op; rd_i = r.rd; rd_we_i = r.we;
    rs1_i = r.rs1; rs1_en_i = r.e1; rs2_i = r.rs2; rs2_en_i = r.e2;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    int div_cyc;
    row_t r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // reset state: a reader of any register issues at once (R9)
    @(negedge clk);
    drive('{1'b1, 2'd0, 5'd20, 1'b1, 5'd1, 1'b1, 5'd2, 1'b1, 1'b0, 5'd0, 4'd9});
    #5;
    chk(9, "issue after reset", int'(issue_o), 1);
    chk(10, "stall after reset", int'(stall_o), 0);
    valid_i = 1'b0;
    @(negedge clk);
    // table phase: cycle 0 starts here
    for (int i = 0; i < NROW; i++) begin
      if (i > 0) @(negedge clk);
      cyc = i;
      drive(TBL[i]);
      #5;
      chk(int'(TBL[i].req), "issue", int'(issue_o), int'(TBL[i].xi));
      chk(10, "stall", int'(stall_o), int'(TBL[i].v && !TBL[i].xi));
      chk(1, "wb_dist", int'(wb_dist_o), int'(TBL[i].xw));
    end
    // R5: waiting divide leaves exactly 25 cycles after the one at cycle 8
    div_cyc = -1;
    for (int k = NROW; k < NROW + 40; k++) begin
      @(negedge clk);
      cyc = k;
      r = '{1'b1, 2'd3, 5'd6, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd25, 4'd5};
      drive(r);
      #5;
      if (issue_o) begin
        div_cyc = k;
        chk(1, "div wb_dist", int'(wb_dist_o), 25);
        break;
      end
    end
    chk(5, "second divide issue cycle", div_cyc, 33);
    // R2: reader of the fresh divide result must hold
    @(negedge clk);
    cyc++;
    drive('{1'b1, 2'd0, 5'd21, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 1'b0, 5'd2, 4'd2});
    #5;
    chk(2, "reader of pending divide", int'(stall_o), 1);
    // R9: reset clears divider, countdowns and bookings
    valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    drive('{1'b1, 2'd3, 5'd6, 1'b1, 5'd6, 1'b1, 5'd5, 1'b1, 1'b1, 5'd25, 4'd9});
    #5;
    chk(9, "divide right after reset", int'(issue_o), 1);
    @(negedge clk);
    valid_i = 1'b0;
    done = 1'b1;
    finish_run();
  end
endmodule